// File: doc/BRIEF.md
# Slow-Trigger Marked-Graph Step Engine

This block evaluates the worst-case firing rate of a linear pipeline of processes that talk through bounded queues and never block. Each queue between transition t and transition t+1 is modelled as a pair of token counters. The forward place holds the items ready to be read. The backward place holds the free slots. When the engine is started it loads an initial marking from a capacity and a unit-delay flag given for each queue. It then advances the graph one step per clock cycle. In each step every transition that is enabled at the start of that step fires at the same time, and a transition that is not enabled waits for the next step. This is the slowest legal triggering order, so it gives the lowest throughput the pipeline can reach.

Each marking it visits is written to a small history table. When the current marking matches an entry already in the table, the engine stops. It reports how many steps the periodic loop takes and how often transition 0 fires within one loop period. The throughput is that firing count divided by the loop length, and it is the same for every transition. The current marking and the fire flags of each step appear at the ports, so the whole trajectory can be observed.

Top module: `mg_step_engine`

## Requirements
- R1: On `start`, a queue with `ud_in` low loads 0 tokens into its forward place and its capacity k into its backward place. Queue q uses bits [q*CAP_W +: CAP_W] of `cap_in`, `fwd_tok` and `bwd_tok`.
- R2: On `start`, a queue with `ud_in` high loads 1 forward token and k-1 backward tokens. A capacity of 0 with `ud_in` high is taken as a capacity of 1.
- R3: During a step, bit t of `fire` is 1 exactly when transition t is enabled. Transition t is enabled when the forward place of queue t-1 is non-zero (transition 0 has no input) and the backward place of queue t is non-zero (the last transition has no output). All enabled transitions fire in the same step.
- R4: The graph advances one step per cycle. For each queue q, the forward count changes by fire[q] minus fire[q+1] and the backward count changes by the opposite amount, so forward plus backward always equals the loaded capacity.
- R5: When the current marking equals a marking stored earlier in the same run, `fire` is 0 in that cycle. On the next cycle `busy` falls and `done` rises, `loop_len` holds the number of steps between the two visits, and the marking no longer changes.
- R6: `loop_fires` holds the number of times transition 0 fired during one loop period, which is 0 when the pipeline is deadlocked.
- R7: If DEPTH markings have been stored without a repeat, the engine stops with `done` and `no_loop` high and `loop_len` and `loop_fires` at 0. A repeat found in that same last cycle takes priority.
- R8: After reset, `busy`, `done` and `fire` are 0. After a run, `done` and the final marking hold until the next `start`, which begins a new run from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load initial marking and begin a run |
| cap_in | input | (N_TRANS-1)*CAP_W | Capacity of each queue |
| ud_in | input | N_TRANS-1 | Unit-delay flag of each queue |
| busy | output | 1 | Engine is stepping |
| done | output | 1 | Run finished |
| no_loop | output | 1 | History filled without a repeat |
| fwd_tok | output | (N_TRANS-1)*CAP_W | Forward place counts |
| bwd_tok | output | (N_TRANS-1)*CAP_W | Backward place counts |
| fire | output | N_TRANS | Transitions firing in this step |
| loop_len | output | $clog2(DEPTH+1) | Loop length in steps |
| loop_fires | output | $clog2(DEPTH+1) | Firings of transition 0 per loop |

## Verification
The initial marking appears on the first cycle after the edge that samples `start`. From then on, each later cycle shows the next marking together with the fire flags computed from it. The repeat is found on the cycle that shows the repeated marking, with `fire` at 0. `done`, `loop_len` and `loop_fires` follow one cycle later. The bench builds the whole expected trajectory from the enable and update rules before it pulses `start`. A monitor then takes one expected entry on each falling edge while `busy` is high and compares the marking and the flags. The final results are compared once `busy` has fallen, and the held marking is checked again a few cycles after that.

// File: rtl/mg_pkg.sv
// Package: shared types for the marked-graph step engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mg_pkg;
    // Run state of the engine.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mg_state_t;
endpackage

// File: rtl/mg_enable.sv
// Module: mg_enable
// Works out which transitions of a linear chain are enabled by the current
// marking. Transition t reads queue t-1 and writes queue t. The first
// transition has no input place and the last has no output place.
// Assumes the marking is stable for the whole cycle. Every enabled
// transition fires when advance is high.
module mg_enable #(
    parameter int N_TRANS = 3,
    parameter int CAP_W   = 4,
    localparam int NQ     = N_TRANS - 1
) (
    input  logic [NQ*CAP_W-1:0] fwd_tok,
    input  logic [NQ*CAP_W-1:0] bwd_tok,
    input  logic                advance,
    output logic [N_TRANS-1:0]  fire
);
    genvar t;
    generate
        for (t = 0; t < N_TRANS; t++) begin : g_tr
            logic in_ok;
            logic out_ok;
            if (t == 0) begin : g_src
                assign in_ok = 1'b1;
            end else begin : g_in
                assign in_ok = (fwd_tok[(t-1)*CAP_W +: CAP_W] != '0);
            end
            if (t == N_TRANS - 1) begin : g_snk
                assign out_ok = 1'b1;
            end else begin : g_out
                assign out_ok = (bwd_tok[t*CAP_W +: CAP_W] != '0);
            end
            // Fire when both sides allow it and the engine is stepping.
            assign fire[t] = advance & in_ok & out_ok;
        end
    endgenerate
endmodule

// File: rtl/mg_queue_places.sv
// Module: mg_queue_places
// Holds the forward (items ready) and backward (free slots) token counts of
// one queue. On load it takes the initial marking. On step it applies the
// firing of the producing and consuming transitions in the same cycle.
// Assumes the caller only steps with fire flags that came from an enable check.
module mg_queue_places #(
    parameter int CAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CAP_W-1:0] init_fwd,
    input  logic [CAP_W-1:0] init_bwd,
    input  logic             step,
    input  logic             fire_src,
    input  logic             fire_dst,
    input  logic             active,
    input  logic [CAP_W-1:0] cap_ref,
    output logic [CAP_W-1:0] fwd,
    output logic [CAP_W-1:0] bwd
);
    // Load or update the two place counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd <= '0;
            bwd <= '0;
        end else if (load) begin
            fwd <= init_fwd;
            bwd <= init_bwd;
        end else if (step) begin
            fwd <= fwd + CAP_W'(fire_src) - CAP_W'(fire_dst);
            bwd <= bwd - CAP_W'(fire_src) + CAP_W'(fire_dst);
        end
    end

    // Tokens of a queue are conserved across every step.
    assert_conserve_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ({1'b0, fwd} + {1'b0, bwd}) == {1'b0, cap_ref});
endmodule

// File: rtl/mg_loop_table.sv
// Module: mg_loop_table
// History of visited markings, with the firing count of transition 0
// recorded at each visit. It compares the current marking against all
// valid entries at once and returns the index and count of the match.
// Assumes entries are written in order, so valid entries are 0..valid_cnt-1.
module mg_loop_table #(
    parameter int MW    = 16,
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [MW-1:0]    wr_mark,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [CNT_W-1:0] valid_cnt,
    input  logic [MW-1:0]    cmp_mark,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [CNT_W-1:0] hit_cnt
);
    logic [MW-1:0]    mark_tab [DEPTH];
    logic [CNT_W-1:0] cnt_tab  [DEPTH];

    // Store the marking and count of the step being taken.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mark_tab[wr_idx] <= wr_mark;
            cnt_tab[wr_idx]  <= wr_cnt;
        end
    end

    // Search the valid entries for the current marking.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_cnt = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (!hit && (CNT_W'(j) < valid_cnt) && (mark_tab[j] == cmp_mark)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(j);
                hit_cnt = cnt_tab[j];
            end
        end
    end
endmodule

// File: rtl/mg_step_engine.sv
// Module: mg_step_engine
// Top level. Steps a chain of N_TRANS transitions under the slow
// triggering policy: one step per cycle, in which every enabled transition
// fires together. It stops when a marking repeats and reports the loop
// length and the firings of transition 0 per loop. It also stops when the
// history table is full.
// Assumes cap_in and ud_in are valid in the cycle start is high.
module mg_step_engine #(
    parameter int N_TRANS = 3,
    parameter int CAP_W   = 4,
    parameter int DEPTH   = 16,
    localparam int NQ     = N_TRANS - 1,
    localparam int MW     = 2 * NQ * CAP_W,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NQ*CAP_W-1:0] cap_in,
    input  logic [NQ-1:0]       ud_in,
    output logic                busy,
    output logic                done,
    output logic                no_loop,
    output logic [NQ*CAP_W-1:0] fwd_tok,
    output logic [NQ*CAP_W-1:0] bwd_tok,
    output logic [N_TRANS-1:0]  fire,
    output logic [CNT_W-1:0]    loop_len,
    output logic [CNT_W-1:0]    loop_fires
);
    import mg_pkg::*;

    mg_state_t            state;
    logic [CNT_W-1:0]     step_n;
    logic [CNT_W-1:0]     fire_cnt;
    logic [NQ*CAP_W-1:0]  cap_q;
    logic [NQ*CAP_W-1:0]  cap_eff;
    logic [NQ*CAP_W-1:0]  init_fwd;
    logic [NQ*CAP_W-1:0]  init_bwd;
    logic                 advance;
    logic                 table_full;
    logic                 hit;
    logic [IDX_W-1:0]     hit_idx;
    logic [CNT_W-1:0]     hit_cnt;
    logic [MW-1:0]        cur_mark;

    assign busy       = (state == ST_RUN);
    assign done       = (state == ST_DONE);
    assign table_full = (step_n == CNT_W'(DEPTH));
    assign advance    = busy && !hit && !table_full;
    assign cur_mark   = {fwd_tok, bwd_tok};

    // Initial marking of every queue from its capacity and unit-delay flag.
    genvar q;
    generate
        for (q = 0; q < NQ; q++) begin : g_q
            logic [CAP_W-1:0] cap_raw;
            assign cap_raw = cap_in[q*CAP_W +: CAP_W];
            // Clamp a zero capacity with a unit delay to one slot.
            assign cap_eff[q*CAP_W +: CAP_W]  = (ud_in[q] && cap_raw == '0) ? CAP_W'(1) : cap_raw;
            assign init_fwd[q*CAP_W +: CAP_W] = ud_in[q] ? CAP_W'(1) : '0;
            assign init_bwd[q*CAP_W +: CAP_W] = cap_eff[q*CAP_W +: CAP_W] - init_fwd[q*CAP_W +: CAP_W];

            mg_queue_places #(.CAP_W(CAP_W)) u_places (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (start),
                .init_fwd (init_fwd[q*CAP_W +: CAP_W]),
                .init_bwd (init_bwd[q*CAP_W +: CAP_W]),
                .step     (advance),
                .fire_src (fire[q]),
                .fire_dst (fire[q+1]),
                .active   (busy),
                .cap_ref  (cap_q[q*CAP_W +: CAP_W]),
                .fwd      (fwd_tok[q*CAP_W +: CAP_W]),
                .bwd      (bwd_tok[q*CAP_W +: CAP_W])
            );
        end
    endgenerate

    mg_enable #(.N_TRANS(N_TRANS), .CAP_W(CAP_W)) u_enable (
        .fwd_tok (fwd_tok),
        .bwd_tok (bwd_tok),
        .advance (advance),
        .fire    (fire)
    );

    mg_loop_table #(.MW(MW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_table (
        .clk       (clk),
        .wr_en     (advance),
        .wr_idx    (step_n[IDX_W-1:0]),
        .wr_mark   (cur_mark),
        .wr_cnt    (fire_cnt),
        .valid_cnt (step_n),
        .cmp_mark  (cur_mark),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_cnt   (hit_cnt)
    );

    // Run control: start, step counting and loop result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            step_n     <= '0;
            fire_cnt   <= '0;
            cap_q      <= '0;
            no_loop    <= 1'b0;
            loop_len   <= '0;
            loop_fires <= '0;
        end else if (start) begin
            state      <= ST_RUN;
            step_n     <= '0;
            fire_cnt   <= '0;
            cap_q      <= cap_eff;
            no_loop    <= 1'b0;
            loop_len   <= '0;
            loop_fires <= '0;
        end else if (state == ST_RUN) begin
            if (hit) begin
                state      <= ST_DONE;
                loop_len   <= step_n - CNT_W'(hit_idx);
                loop_fires <= fire_cnt - hit_cnt;
            end else if (table_full) begin
                state   <= ST_DONE;
                no_loop <= 1'b1;
            end else begin
                step_n   <= step_n + 1'b1;
                fire_cnt <= fire_cnt + CNT_W'(fire[0]);
            end
        end
    end

    // Nothing fires outside a run.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> fire == '0);

    // A finished run holds its marking until restarted.
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fwd_tok) && $stable(bwd_tok)));

    // A detected loop has a length within the history depth.
    assert_loop_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_loop) |-> (loop_len != '0 && loop_len <= CNT_W'(DEPTH)));

    // A transition fires at most once per step of the loop.
    assert_fires_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> loop_fires <= loop_len);

    // Running out of history reports no loop length.
    assert_no_loop_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_loop) |-> (loop_len == '0 && loop_fires == '0));
endmodule

// File: tb/mg_step_engine_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard of the marked-graph step engine. The driver builds the
// expected trajectory and pushes it into a queue. A monitor pops one entry
// per cycle while the engine is busy.
module mg_step_engine_tb;
    localparam int N_TRANS = 3;
    localparam int CAP_W   = 4;
    localparam int DEPTH   = 4;
    localparam int NQ      = N_TRANS - 1;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    typedef struct {
        logic [NQ*CAP_W-1:0] f;
        logic [NQ*CAP_W-1:0] b;
        logic [N_TRANS-1:0]  fr;
        string               tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [NQ*CAP_W-1:0] cap_in = '0;
    logic [NQ-1:0]       ud_in = '0;
    logic                busy, done, no_loop;
    logic [NQ*CAP_W-1:0] fwd_tok, bwd_tok;
    logic [N_TRANS-1:0]  fire;
    logic [CNT_W-1:0]    loop_len, loop_fires;

    int   n_run = 0;
    int   n_fail = 0;
    exp_t exp_q[$];
    int   exp_len, exp_fires;
    bit   exp_noloop;

    always #2 clk = ~clk;

    mg_step_engine #(.N_TRANS(N_TRANS), .CAP_W(CAP_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cap_in(cap_in), .ud_in(ud_in),
        .busy(busy), .done(done), .no_loop(no_loop), .fwd_tok(fwd_tok),
        .bwd_tok(bwd_tok), .fire(fire), .loop_len(loop_len), .loop_fires(loop_fires)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Monitor: compare one step of the trajectory per busy cycle.
    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected busy cycle", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(fwd_tok == e.f, e.tag, "forward places", fwd_tok, e.f);
                check(bwd_tok == e.b, e.tag, "backward places", bwd_tok, e.b);
                check(fire == e.fr, e.tag, "fire flags", fire, e.fr);
            end
        end
    end

    // Driver: model the chain from the requirements and run one case.
    task automatic run_case(input int c0, input int c1, input bit u0, input bit u1);
        int f[NQ];
        int b[NQ];
        int cp[NQ];
        bit ud[NQ];
        logic [2*NQ*CAP_W-1:0] hist[$];
        cp[0] = c0; cp[1] = c1; ud[0] = u0; ud[1] = u1;
        for (int q = 0; q < NQ; q++) begin
            if (ud[q] && cp[q] == 0) cp[q] = 1;
            f[q] = ud[q] ? 1 : 0;
            b[q] = cp[q] - f[q];
        end
        exp_noloop = 1'b0; exp_len = 0; exp_fires = 0;
        for (int s = 0; s <= DEPTH; s++) begin
            exp_t e;
            logic [2*NQ*CAP_W-1:0] m;
            int hitj;
            for (int q = 0; q < NQ; q++) begin
                e.f[q*CAP_W +: CAP_W] = CAP_W'(f[q]);
                e.b[q*CAP_W +: CAP_W] = CAP_W'(b[q]);
            end
            m = {e.f, e.b};
            e.tag = (s == 0) ? ((u0 || u1) ? "R2" : "R1") : "R3 R4";
            hitj = -1;
            for (int j = 0; j < hist.size(); j++) if (hitj < 0 && hist[j] == m) hitj = j;
            e.fr = '0;
            if (hitj >= 0 || s == DEPTH) begin
                if (hitj >= 0) begin
                    int cnt_s, cnt_j;
                    exp_len = s - hitj;
                    cnt_s = 0; cnt_j = 0;
                    foreach (exp_q[k]) begin
                        if (k >= exp_q.size() - s && exp_q[k].fr[0]) begin
                            cnt_s++;
                            if (k < exp_q.size() - s + hitj) cnt_j++;
                        end
                    end
                    exp_fires = cnt_s - cnt_j;
                end else begin
                    exp_noloop = 1'b1;
                end
                exp_q.push_back(e);
                break;
            end
            for (int t = 0; t < N_TRANS; t++) begin
                bit en;
                en = 1'b1;
                if (t > 0 && f[t-1] == 0) en = 1'b0;
                if (t < N_TRANS - 1 && b[t] == 0) en = 1'b0;
                e.fr[t] = en;
            end
            exp_q.push_back(e);
            hist.push_back(m);
            for (int q = 0; q < NQ; q++) begin
                f[q] = f[q] + int'(e.fr[q]) - int'(e.fr[q+1]);
                b[q] = b[q] - int'(e.fr[q]) + int'(e.fr[q+1]);
            end
        end
        @(negedge clk);
        cap_in = {CAP_W'(c1), CAP_W'(c0)};
        ud_in  = {u1, u0};
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        check(done == 1'b1, "R5", "done after run", done, 1);
        check(exp_q.size() == 0, "R5", "trajectory fully consumed", exp_q.size(), 0);
        check(no_loop == exp_noloop, "R7", "no_loop flag", no_loop, exp_noloop);
        check(loop_len == CNT_W'(exp_len), exp_noloop ? "R7" : "R5", "loop length", loop_len, exp_len);
        check(loop_fires == CNT_W'(exp_fires), "R6", "loop firings", loop_fires, exp_fires);
        begin
            logic [NQ*CAP_W-1:0] hf, hb;
            hf = fwd_tok; hb = bwd_tok;
            repeat (3) @(negedge clk);
            check(done && fwd_tok == hf && bwd_tok == hb && fire == '0, "R8",
                  "held result", {fwd_tok, bwd_tok}, {hf, hb});
        end
        exp_q.delete();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && fire == '0, "R8", "reset state", {busy, done, fire}, 0);
        run_case(1, 1, 1'b0, 1'b0);   // R1 R5: loop of 2, one firing
        run_case(2, 2, 1'b0, 1'b0);   // R5: loop of 1, one firing
        run_case(0, 1, 1'b0, 1'b0);   // R6: deadlock, zero firings
        run_case(1, 1, 1'b1, 1'b0);   // R2: unit delay on first queue
        run_case(2, 0, 1'b0, 1'b1);   // R2: zero capacity with unit delay
        run_case(3, 1, 1'b0, 1'b0);   // R7: history fills first
        run_case(1, 1, 1'b0, 1'b0);   // R8: restart after a finished run
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule